// File: doc/BRIEF.md
# Infrared Run-Length Sampler

This block turns the waveform from a consumer-infrared receiver into a stream of run-length symbols. It divides the module clock down to a fixed sample rate. With an 8 MHz clock and a divide ratio of 64, that rate is 125 kHz, so one sample lasts 8 µs. The block synchronises the receiver line and can invert its polarity. It rejects short glitches, and then measures how many samples each stretch of constant level lasts.

Each finished stretch is written toward a receive FIFO as one byte. Bit 7 of the byte holds the level and bits 6:0 hold the length. A space that lasts longer than a programmable idle limit closes the packet: the block pulses a packet-end output and does not write that space. The next packet starts with the first pulse that follows. Protocol decoding and register access sit outside the block.

Top module: `cir_run_encoder`

## Requirements
- R1: The block is active only when `glb_en_i` and `rx_en_i` are both 1 and `mode_i` is 2'b11. While it is active, it takes one sample every `PRESCALE` clocks (default 64). The sample is taken from `ir_i` after a two-flop synchroniser. A write strobe or packet-end pulse is high for exactly the one clock after the edge on which the sample was taken.
- R2: Each written byte holds the level in bit 7, where 1 means pulse and 0 means space. Bits 6:0 hold the run length in samples minus one.
- R3: When `inv_i` is 1, the synchronised input is inverted before any other processing. This lets a receiver with an active-low output be used.
- R4: A change of level that lasts `noise_thr_i` samples or fewer is ignored, and its samples count toward the surrounding run. A change that lasts one sample longer than that is accepted, and the lengths of the accepted runs are kept. When `noise_thr_i` is 0, no filtering takes place.
- R5: A run longer than 128 samples is written as several bytes that all carry the same level. Every full 128-sample chunk is written as a length field of 127, and the remaining samples go into the last byte.
- R6: When a space lasts more than `idle_thr_i` samples, `pkt_end_o` pulses for one clock. The unfinished part of that space is not written. Full 128-sample chunks that were already written stay written.
- R7: A space of `idle_thr_i` samples or fewer, followed by a pulse, is written as a space byte.
- R8: After reset, after re-enabling, and after a packet end, nothing is written until a pulse level is seen. The first run that follows starts its count from zero.
- R9: While the block is not active, the divider, the filter and the run state are held in reset. `wr_o` and `pkt_end_o` stay low.
- R10: While `rst_ni` is low, `wr_o`, `wr_data_o` and `pkt_end_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 1 | Raw line from the infrared receiver |
| glb_en_i | input | 1 | Global enable |
| rx_en_i | input | 1 | Receive enable |
| mode_i | input | 2 | Operating mode; 2'b11 selects infrared sampling |
| inv_i | input | 1 | Invert the input polarity |
| noise_thr_i | input | NOISE_W (6) | Glitch limit, in samples |
| idle_thr_i | input | IDLE_W (8) | Idle limit, in samples |
| wr_o | output | 1 | One-clock write strobe toward the receive FIFO |
| wr_data_o | output | 8 | Run symbol: {level, length-1} |
| pkt_end_o | output | 1 | One-clock packet-end pulse |

## Verification
The checks on space length and on packet framing assume that `idle_thr_i`, `noise_thr_i` and `inv_i` stay constant while the block is active. The stimulus therefore changes them only while `mode_i` is held away from 2'b11. Each level on `ir_i` is held for a whole number of sample periods, so every stretch spans an exact sample count whatever the phase of the divider. Every scenario ends with a space long enough to close the packet, so each scenario starts from an idle block.

// File: rtl/cir_enc_pkg.sv
`timescale 1ns/1ps
package cir_enc_pkg;
  localparam int unsigned LEN_W   = 7;
  localparam logic [1:0]  MODE_IR = 2'b11;

  typedef struct packed {
    logic             lvl;
    logic [LEN_W-1:0] len;
  } run_sym_t;
endpackage

// File: rtl/cir_sync.sv
`timescale 1ns/1ps
module cir_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cir_prescaler.sv
`timescale 1ns/1ps
module cir_prescaler #(
  parameter int unsigned DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cir_glitch_filter.sv
`timescale 1ns/1ps
module cir_glitch_filter #(
  parameter int unsigned NW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic          smp_i,
  input  logic [NW-1:0] thr_i,
  output logic          lvl_o
);
  logic          lvl_q, lvl_d;
  logic [NW-1:0] alt_q, alt_d;

  // a new level is accepted on its (thr+1)-th consecutive sample
  always_comb begin
    lvl_d = lvl_q;
    alt_d = alt_q;
    if (smp_i == lvl_q) begin
      alt_d = '0;
    end else if (alt_q >= thr_i) begin
      lvl_d = smp_i;
      alt_d = '0;
    end else begin
      alt_d = alt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      alt_q <= '0;
    end else if (clr_i) begin
      lvl_q <= 1'b0;
      alt_q <= '0;
    end else if (tick_i) begin
      lvl_q <= lvl_d;
      alt_q <= alt_d;
    end
  end

  assign lvl_o = lvl_d;
endmodule

// File: rtl/cir_run_packer.sv
`timescale 1ns/1ps
module cir_run_packer
  import cir_enc_pkg::*;
#(
  parameter int unsigned IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic          lvl_i,
  input  logic [IW-1:0] idle_thr_i,
  output logic          wr_o,
  output run_sym_t      sym_o,
  output logic          pkt_end_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic             act_q, act_d;
  logic             lvl_q, lvl_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [IW:0]      sp_q, sp_d;
  logic             wr_d, pkt_d;
  run_sym_t         sym_d;

  always_comb begin
    act_d = act_q;
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    sp_d  = sp_q;
    sym_d = sym_o;
    wr_d  = 1'b0;
    pkt_d = 1'b0;
    if (tick_i) begin
      if (!act_q) begin
        // idle: wait for a pulse
        if (lvl_i) begin
          act_d = 1'b1;
          lvl_d = 1'b1;
          cnt_d = '0;
        end
      end else if (lvl_i != lvl_q) begin
        wr_d  = 1'b1;
        sym_d = '{lvl: lvl_q, len: cnt_q};
        lvl_d = lvl_i;
        cnt_d = '0;
        if (!lvl_i) begin
          sp_d = (IW+1)'(1);
          if (idle_thr_i == '0) begin
            pkt_d = 1'b1;
            act_d = 1'b0;
          end
        end
      end else if (!lvl_i && ({1'b0, idle_thr_i} <= sp_q)) begin
        // packet end takes priority over a chunk write
        pkt_d = 1'b1;
        act_d = 1'b0;
      end else begin
        if (cnt_q == LEN_MAX) begin
          wr_d  = 1'b1;
          sym_d = '{lvl: lvl_q, len: LEN_MAX};
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        if (!lvl_i) sp_d = sp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      lvl_q     <= 1'b0;
      cnt_q     <= '0;
      sp_q      <= '0;
      wr_o      <= 1'b0;
      pkt_end_o <= 1'b0;
      sym_o     <= '0;
    end else if (clr_i) begin
      act_q     <= 1'b0;
      lvl_q     <= 1'b0;
      cnt_q     <= '0;
      sp_q      <= '0;
      wr_o      <= 1'b0;
      pkt_end_o <= 1'b0;
      sym_o     <= '0;
    end else begin
      act_q     <= act_d;
      lvl_q     <= lvl_d;
      cnt_q     <= cnt_d;
      sp_q      <= sp_d;
      wr_o      <= wr_d;
      pkt_end_o <= pkt_d;
      sym_o     <= sym_d;
    end
  end
endmodule

// File: rtl/cir_run_encoder.sv
`timescale 1ns/1ps
module cir_run_encoder
  import cir_enc_pkg::*;
#(
  parameter int unsigned PRESCALE    = 64,
  parameter int unsigned NOISE_W     = 6,
  parameter int unsigned IDLE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ir_i,
  input  logic               glb_en_i,
  input  logic               rx_en_i,
  input  logic [1:0]         mode_i,
  input  logic               inv_i,
  input  logic [NOISE_W-1:0] noise_thr_i,
  input  logic [IDLE_W-1:0]  idle_thr_i,
  output logic               wr_o,
  output logic [7:0]         wr_data_o,
  output logic               pkt_end_o
);
  logic     en_w, tick_w, raw_w, smp_w, flt_w;
  run_sym_t sym_w;

  assign en_w = glb_en_i & rx_en_i & (mode_i == MODE_IR);

  cir_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ir_i),
    .q_o   (raw_w)
  );

  assign smp_w = raw_w ^ inv_i;

  cir_prescaler #(.DIV(PRESCALE)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_w),
    .tick_o(tick_w)
  );

  cir_glitch_filter #(.NW(NOISE_W)) u_flt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!en_w),
    .tick_i(tick_w),
    .smp_i (smp_w),
    .thr_i (noise_thr_i),
    .lvl_o (flt_w)
  );

  cir_run_packer #(.IW(IDLE_W)) u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!en_w),
    .tick_i    (tick_w),
    .lvl_i     (flt_w),
    .idle_thr_i(idle_thr_i),
    .wr_o      (wr_o),
    .sym_o     (sym_w),
    .pkt_end_o (pkt_end_o)
  );

  assign wr_data_o = sym_w;
endmodule

// File: rtl/cir_run_encoder_chk.sv
`timescale 1ns/1ps
module cir_run_encoder_chk #(
  parameter int unsigned IDLE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              tick_i,
  input logic              wr_o,
  input logic [7:0]        wr_data_o,
  input logic              pkt_end_o,
  input logic [IDLE_W-1:0] idle_thr_i
);
  logic idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idle_q <= 1'b1;
    else if (pkt_end_o || !en_i) idle_q <= 1'b1;
    else if (wr_o)              idle_q <= 1'b0;
  end

  // R9
  en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!wr_o && !pkt_end_o));

  // R1
  tick_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o || pkt_end_o) |-> $past(tick_i));

  // R7
  space_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !wr_data_o[7]) |-> (int'(wr_data_o[6:0]) < int'(idle_thr_i)));

  // R8
  first_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && idle_q) |-> wr_data_o[7]);

  // R6
  pkt_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_o |=> !pkt_end_o);
endmodule

bind cir_run_encoder cir_run_encoder_chk #(.IDLE_W(IDLE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_w),
  .tick_i    (tick_w),
  .wr_o      (wr_o),
  .wr_data_o (wr_data_o),
  .pkt_end_o (pkt_end_o),
  .idle_thr_i(idle_thr_i)
);

// File: tb/sim_cir_run_encoder.sv
`timescale 1ns/1ps
module sim_cir_run_encoder;
  localparam int P = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ir_i = 1'b0;
  logic       glb_en_i = 1'b1;
  logic       rx_en_i = 1'b1;
  logic [1:0] mode_i = 2'b11;
  logic       inv_i = 1'b0;
  logic [5:0] noise_thr_i = 6'd0;
  logic [7:0] idle_thr_i = 8'd5;
  logic       wr_o, pkt_end_o;
  logic [7:0] wr_data_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int ev[$];

  always #4 clk_i = ~clk_i;

  cir_run_encoder #(.PRESCALE(P)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ir_i(ir_i), .glb_en_i(glb_en_i),
    .rx_en_i(rx_en_i), .mode_i(mode_i), .inv_i(inv_i),
    .noise_thr_i(noise_thr_i), .idle_thr_i(idle_thr_i),
    .wr_o(wr_o), .wr_data_o(wr_data_o), .pkt_end_o(pkt_end_o)
  );

  // behavioural reference: whole-run lengths, chunks derived by modulo
  int m_s1, m_s2, m_pc, m_alt, m_flt, m_act, m_lvl, m_len;
  int e_wr, e_dat, e_pkt;

  task automatic m_emit(input int lvl, input int len_field);
    e_wr  = 1;
    e_dat = lvl * 128 + len_field;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_pc = 0; m_alt = 0; m_flt = 0;
      m_act = 0; m_lvl = 0; m_len = 0;
      e_wr = 0; e_dat = 0; e_pkt = 0;
    end else begin
      e_wr = 0; e_pkt = 0;
      if (!(glb_en_i && rx_en_i && mode_i == 2'b11)) begin
        m_pc = 0; m_alt = 0; m_flt = 0; m_act = 0; m_lvl = 0; m_len = 0; e_dat = 0;
      end else if (m_pc != P - 1) begin
        m_pc++;
      end else begin
        int s;
        m_pc = 0;
        s = m_s2 ^ int'(inv_i);
        if (s == m_flt) m_alt = 0;
        else if (m_alt >= int'(noise_thr_i)) begin m_flt = s; m_alt = 0; end
        else m_alt++;
        if (m_act == 0) begin
          if (m_flt == 1) begin m_act = 1; m_lvl = 1; m_len = 1; end
        end else if (m_flt != m_lvl) begin
          m_emit(m_lvl, (m_len - 1) % 128);
          m_lvl = m_flt; m_len = 1;
          if (m_lvl == 0 && m_len > int'(idle_thr_i)) begin e_pkt = 1; m_act = 0; end
        end else begin
          m_len++;
          if (m_lvl == 0 && m_len > int'(idle_thr_i)) begin e_pkt = 1; m_act = 0; end
          else if ((m_len - 1) % 128 == 0) m_emit(m_lvl, 127);
        end
      end
      m_s2 = m_s1;
      m_s1 = int'(ir_i);
    end
  end

  // per-cycle comparison and event capture
  always @(negedge clk_i) begin
    if (rst_ni) begin
      checks++;
      if (int'(wr_o) != e_wr) begin
        errors++;
        $display("FAIL R1 write strobe at %0t: actual=%0d expected=%0d", $time, wr_o, e_wr);
      end else if (e_wr == 1 && int'(wr_data_o) != e_dat) begin
        errors++;
        $display("FAIL R2 byte at %0t: actual=%02h expected=%02h", $time, wr_data_o, e_dat);
      end else if (int'(pkt_end_o) != e_pkt) begin
        errors++;
        $display("FAIL R6 packet end at %0t: actual=%0d expected=%0d", $time, pkt_end_o, e_pkt);
      end
      if (wr_o) ev.push_back(int'(wr_data_o));
      if (pkt_end_o) ev.push_back(256);
    end
  end

  task automatic run(input logic lvl, input int n);
    ir_i = lvl;
    repeat (n * P) @(negedge clk_i);
  endtask

  task automatic cfg(input int nz, input int idl, input logic inv, input logic line);
    mode_i = 2'b00;
    @(negedge clk_i);
    noise_thr_i = 6'(nz);
    idle_thr_i  = 8'(idl);
    inv_i       = inv;
    ir_i        = line;
    repeat (3) @(negedge clk_i);
    mode_i = 2'b11;
    ev.delete();
  endtask

  task automatic check_seq(input string tag, input int n, input int e [0:7]);
    string act_s, exp_s;
    bit bad;
    act_s = ""; exp_s = "";
    bad = (ev.size() != n);
    foreach (ev[i]) act_s = {act_s, $sformatf("%0h ", ev[i])};
    for (int i = 0; i < n; i++) begin
      exp_s = {exp_s, $sformatf("%0h ", e[i])};
      if (i < ev.size() && ev[i] != e[i]) bad = 1'b1;
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: actual=[%s] expected=[%s]", tag, act_s, exp_s);
    end
    ev.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset values
    checks++;
    if (wr_o !== 1'b0 || pkt_end_o !== 1'b0 || wr_data_o !== 8'h00) begin
      errors++;
      $display("FAIL R10 reset: actual=%b/%b/%02h expected=0/0/00", wr_o, pkt_end_o, wr_data_o);
    end
    rst_ni = 1'b1;

    // R2 R7 R8 basic runs, idle 5, no filtering
    cfg(0, 5, 1'b0, 1'b0);
    run(0, 10); run(1, 3); run(0, 2); run(1, 4); run(0, 20);
    check_seq("R2 R7 basic runs", 4, '{'h82, 'h01, 'h83, 256, 0, 0, 0, 0});

    // R4 one-sample glitch swallowed at threshold 1
    cfg(1, 5, 1'b0, 1'b0);
    run(1, 3); run(0, 1); run(1, 2); run(0, 12);
    check_seq("R4 glitch merged", 2, '{'h85, 256, 0, 0, 0, 0, 0, 0});

    // R4 boundary at threshold 2: 2 ignored, 3 accepted
    cfg(2, 10, 1'b0, 1'b0);
    run(1, 5); run(0, 2); run(1, 5); run(0, 3); run(1, 4); run(0, 20);
    check_seq("R4 threshold boundary", 4, '{'h8b, 'h02, 'h83, 256, 0, 0, 0, 0});

    // R5 long pulses
    cfg(0, 5, 1'b0, 1'b0);
    run(1, 300); run(0, 10);
    check_seq("R5 300-sample pulse", 4, '{'hff, 'hff, 'hab, 256, 0, 0, 0, 0});
    run(1, 128); run(0, 10);
    check_seq("R5 exact 128 pulse", 2, '{'hff, 256, 0, 0, 0, 0, 0, 0});

    // R5 R6 long spaces with idle 200
    cfg(0, 200, 1'b0, 1'b0);
    run(1, 1); run(0, 150); run(1, 1); run(0, 250);
    check_seq("R5 R6 long spaces", 6, '{'h80, 'h7f, 'h15, 'h80, 'h7f, 256, 0, 0});

    // R7 space equal to idle limit kept
    cfg(0, 8, 1'b0, 1'b0);
    run(1, 2); run(0, 8); run(1, 2); run(0, 20);
    check_seq("R7 space at idle limit", 4, '{'h81, 'h07, 'h81, 256, 0, 0, 0, 0});

    // R6 R8 space one over limit ends packet, next run restarts
    run(1, 2); run(0, 9); run(1, 2); run(0, 20);
    check_seq("R6 R8 packet split", 4, '{'h81, 256, 'h81, 256, 0, 0, 0, 0});

    // R3 inverted line: low is pulse
    cfg(0, 5, 1'b1, 1'b1);
    run(1, 6); run(0, 4); run(1, 10);
    check_seq("R3 inverted input", 2, '{'h83, 256, 0, 0, 0, 0, 0, 0});

    // R9 wrong mode: no output
    cfg(0, 5, 1'b0, 1'b0);
    mode_i = 2'b01;
    run(1, 5); run(0, 3); run(1, 5); run(0, 10);
    check_seq("R9 mode not IR", 0, '{0, 0, 0, 0, 0, 0, 0, 0});

    // R9 receive enable low
    mode_i = 2'b11; rx_en_i = 1'b0;
    run(1, 5); run(0, 10);
    check_seq("R9 receive disabled", 0, '{0, 0, 0, 0, 0, 0, 0, 0});

    // R9 global enable low, then R8 restart after enabling
    rx_en_i = 1'b1; glb_en_i = 1'b0;
    run(1, 5); run(0, 2);
    glb_en_i = 1'b1;
    run(0, 3); run(1, 2); run(0, 10);
    check_seq("R9 R8 global enable", 2, '{'h81, 256, 0, 0, 0, 0, 0, 0});

    // R1 default-rate note: the model checks tick spacing every cycle
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule